// File: doc/BRIEF.md
# Redundant clock failure monitor and selector

This block watches a pair of redundant reference clocks with a faster free-running sampling clock. Each reference is brought into the sampling domain through its own synchronizer. A per-input counter restarts on every level change of that input. When an input holds one level for longer than a configured number of sampling cycles, the block raises a sticky alarm for it. Both inputs are watched at all times, whichever of them is in use.

A select pin names the preferred (primary) input. The block drives a select line for a downstream clock mux, plus a one-hot indicator of the input in use. The selection moves to the other input only when the input in use fails and the other input is still healthy. A manual override makes the selection follow the select pin directly, with no automatic moves. A single-cycle alarm-clear pulse clears both alarms. After an automatic move, the selection returns to the primary only once the alarms have been cleared and the primary has been seen toggling again.

Top module: `clk_fail_selector`

## Requirements
- R1: An input that holds a constant level sets its alarm bit (alarm[0] for ref_in[0], alarm[1] for ref_in[1]) no earlier than TIMEOUT_CYC sampling cycles and no later than TIMEOUT_CYC+10 cycles after it stops toggling. This applies whether or not that input is selected.
- R2: An input that toggles with a half period well below TIMEOUT_CYC sampling cycles never sets its alarm.
- R3: An alarm bit stays 1 after its input starts toggling again, until alarm_clr is pulsed.
- R4: A one-cycle pulse on alarm_clr clears both alarm bits on the next cycle. Clear wins over a new failure in that cycle. An input that is still stuck sets its alarm again after another full timeout.
- R5: With override low, when the alarm of the input in use (mux_sel, where 0 selects ref_in[0]) sets while the other input's alarm is clear, mux_sel moves to the other input on the next cycle.
- R6: A failure of the input not in use sets only its alarm and leaves mux_sel unchanged.
- R7: While override is high, mux_sel takes the value of sel_pin on the next cycle and never moves on its own. Alarms still latch.
- R8: After an automatic move, mux_sel stays on the secondary input until both of these hold: the primary's alarm has been cleared, and an edge of the primary has been seen since that clear. It then returns to sel_pin. In normal tracking, mux_sel follows sel_pin on the next cycle.
- R9: With override low and both alarm bits set, mux_sel holds its value.
- R10: On reset, alarm is 00, mux_sel is 0 and sel_onehot is 01. At all times sel_onehot[1] equals mux_sel and sel_onehot[0] equals its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 2 | The two redundant reference clocks, asynchronous |
| sel_pin | input | 1 | Primary choice: 0 names ref_in[0], 1 names ref_in[1] |
| override | input | 1 | High: selection follows sel_pin, no automatic moves |
| alarm_clr | input | 1 | One-cycle pulse that clears both alarms |
| alarm | output | 2 | Sticky per-input failure flags |
| mux_sel | output | 1 | Select line for the downstream clock mux |
| sel_onehot | output | 2 | One-hot indicator of the input in use |

## Verification
The bench runs a fixed sequence of patterns on a configuration with a timeout of 20 sampling cycles. In the first pattern both inputs toggle, which shows that no false alarm is raised. It then freezes the unselected input and then the selected one. These two cases separate a flag that only latches from a flag that moves the selection. The bench also freezes an input, clears the alarm while the input is still stuck, and then restarts the input. These cases separate re-arming from recovery, and they show when the selection may return to the primary. The last patterns freeze both inputs and drive the override pin. They show that the selection holds when both inputs are bad and that it follows the pin while the alarms keep latching.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  typedef enum logic {
    SEL_TRACK = 1'b0,  // following sel_pin
    SEL_HELD  = 1'b1   // parked on the secondary after a failure
  } sel_state_t;
endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkmon_watch.sv
module clkmon_watch #(
  parameter int LIMIT = 24,
  parameter int SYNC  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic raw,
  output logic stuck,
  output logic alive
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic          lvl;
  logic          lvl_d;
  logic          toggled;
  logic [CW-1:0] cnt;

  clkmon_sync #(.STAGES(SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl;
  end

  assign toggled = lvl ^ lvl_d;

  // time since the last edge, saturating at the limit
  always_ff @(posedge clk) begin
    if (rst || clr || toggled) cnt <= '0;
    else if (cnt != LIM)       cnt <= cnt + 1'b1;
  end

  assign stuck = (cnt == LIM);

  // an edge has been observed since the last clear
  always_ff @(posedge clk) begin
    if (rst || clr) alive <= 1'b0;
    else if (toggled) alive <= 1'b1;
  end
endmodule

// File: rtl/clkmon_select.sv
module clkmon_select
  import clkmon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_pin,
  input  logic       override,
  input  logic [1:0] alarm,
  input  logic [1:0] alive,
  output logic       cur,
  output logic       cur_nxt
);
  sel_state_t st, st_nxt;

  always_comb begin
    cur_nxt = cur;
    st_nxt  = st;
    if (override) begin
      cur_nxt = sel_pin;
      st_nxt  = SEL_TRACK;
    end else if (&alarm) begin
      // both inputs bad: keep the last choice
      cur_nxt = cur;
    end else if (st == SEL_TRACK || cur == sel_pin) begin
      if (alarm[sel_pin]) begin
        cur_nxt = ~sel_pin;
        st_nxt  = SEL_HELD;
      end else begin
        cur_nxt = sel_pin;
        st_nxt  = SEL_TRACK;
      end
    end else if (!alarm[sel_pin] && alive[sel_pin]) begin
      cur_nxt = sel_pin;
      st_nxt  = SEL_TRACK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= 1'b0;
      st  <= SEL_TRACK;
    end else begin
      cur <= cur_nxt;
      st  <= st_nxt;
    end
  end
endmodule

// File: rtl/clk_fail_selector.sv
module clk_fail_selector #(
  parameter int TIMEOUT_CYC = 24,
  parameter int SYNC_STAGES = 2,
  parameter int N_IN        = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ref_in,
  input  logic       sel_pin,
  input  logic       override,
  input  logic       alarm_clr,
  output logic [1:0] alarm,
  output logic       mux_sel,
  output logic [1:0] sel_onehot
);
  logic [N_IN-1:0] stuck;
  logic [N_IN-1:0] alive;
  logic            cur_nxt;

  for (genvar g = 0; g < N_IN; g++) begin : g_watch
    clkmon_watch #(.LIMIT(TIMEOUT_CYC), .SYNC(SYNC_STAGES)) u_watch (
      .clk   (clk),
      .rst   (rst),
      .clr   (alarm_clr),
      .raw   (ref_in[g]),
      .stuck (stuck[g]),
      .alive (alive[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || alarm_clr) alarm <= '0;
    else                  alarm <= alarm | stuck;
  end

  clkmon_select u_sel (
    .clk      (clk),
    .rst      (rst),
    .sel_pin  (sel_pin),
    .override (override),
    .alarm    (alarm),
    .alive    (alive),
    .cur      (mux_sel),
    .cur_nxt  (cur_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) sel_onehot <= 2'b01;
    else     sel_onehot <= {cur_nxt, ~cur_nxt};
  end
endmodule

// File: rtl/clkmon_checker.sv
module clkmon_checker (
  input logic       clk,
  input logic       rst,
  input logic       sel_pin,
  input logic       override,
  input logic       alarm_clr,
  input logic [1:0] alarm,
  input logic       mux_sel,
  input logic [1:0] sel_onehot
);
  AST_ALARM_STICKY0: assert property (@(posedge clk) disable iff (rst)
    alarm[0] && !alarm_clr |=> alarm[0]); // R3
  AST_ALARM_STICKY1: assert property (@(posedge clk) disable iff (rst)
    alarm[1] && !alarm_clr |=> alarm[1]); // R3
  AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (rst)
    alarm_clr |=> alarm == 2'b00); // R4
  AST_FAILOVER: assert property (@(posedge clk) disable iff (rst)
    !override && mux_sel == sel_pin && alarm[sel_pin] && !alarm[~sel_pin]
    |=> mux_sel != $past(sel_pin)); // R5
  AST_NO_SPURIOUS_MOVE: assert property (@(posedge clk) disable iff (rst)
    !override && mux_sel == sel_pin && !alarm[sel_pin]
    |=> mux_sel == $past(sel_pin)); // R6
  AST_OVERRIDE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    override |=> mux_sel == $past(sel_pin)); // R7
  AST_BOTH_BAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !override && alarm == 2'b11 |=> $stable(mux_sel)); // R9
  AST_ONEHOT_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot(sel_onehot) && sel_onehot[1] == mux_sel); // R10
endmodule

bind clk_fail_selector clkmon_checker u_chk (.*);

// File: tb/sim_clk_fail_selector.sv
module sim_clk_fail_selector;
  localparam int LIM = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ref_in = 2'b00;
  logic       sel_pin = 1'b0;
  logic       override = 1'b0;
  logic       alarm_clr = 1'b0;
  logic [1:0] alarm;
  logic       mux_sel;
  logic [1:0] sel_onehot;

  logic [1:0] run = 2'b00;
  logic [1:0] lvl = 2'b00;
  int checks = 0;
  int fails  = 0;

  clk_fail_selector #(.TIMEOUT_CYC(LIM)) u0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .sel_pin(sel_pin),
    .override(override), .alarm_clr(alarm_clr), .alarm(alarm),
    .mux_sel(mux_sel), .sel_onehot(sel_onehot)
  );

  always #5 clk = ~clk;

  // reference clocks: half period of 3 sampling cycles while running
  always #30 begin
    for (int i = 0; i < 2; i++) begin
      if (run[i]) ref_in[i] = ~ref_in[i];
      else        ref_in[i] = lvl[i];
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    alarm_clr = 1'b1;
    cyc(1);
    alarm_clr = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // freeze input i at level v and check the alarm window
  task automatic freeze(input int i, input logic v);
    run[i] = 1'b0;
    lvl[i] = v;
    cyc(LIM - 2);
    chk("R1 alarm not early", int'(alarm[i]), 0);
    cyc(12);
    chk("R1 alarm set", int'(alarm[i]), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    cyc(3);
    chk("R10 reset alarm", int'(alarm), 0);
    chk("R10 reset mux_sel", int'(mux_sel), 0);
    chk("R10 reset onehot", int'(sel_onehot), 1);
    run = 2'b11;
    rst = 1'b0;
    cyc(60);
    chk("R2 no false alarm", int'(alarm), 0);
    chk("R8 tracks pin 0", int'(mux_sel), 0);

    sel_pin = 1'b1; cyc(2);
    chk("R8 tracks pin 1", int'(mux_sel), 1);
    chk("R10 onehot 10", int'(sel_onehot), 2);
    sel_pin = 1'b0; cyc(2);
    chk("R10 onehot 01", int'(sel_onehot), 1);

    // unselected input fails
    freeze(1, 1'b0);
    chk("R6 no switch", int'(mux_sel), 0);
    chk("R6 alarm0 clear", int'(alarm[0]), 0);
    run[1] = 1'b1; cyc(40);
    chk("R3 sticky after recovery", int'(alarm[1]), 1);
    pulse_clr();
    chk("R4 clear", int'(alarm), 0);
    cyc(40);
    chk("R2 recovered no alarm", int'(alarm), 0);

    // clear while still stuck re-arms
    run[1] = 1'b0; lvl[1] = 1'b1; cyc(LIM + 10);
    chk("R1 stuck high", int'(alarm[1]), 1);
    pulse_clr();
    chk("R4 clear while stuck", int'(alarm[1]), 0);
    cyc(LIM - 5);
    chk("R4 not before timeout", int'(alarm[1]), 0);
    cyc(15);
    chk("R4 re-set after timeout", int'(alarm[1]), 1);
    run[1] = 1'b1; cyc(10); pulse_clr(); cyc(10);

    // selected input fails
    freeze(0, 1'b1);
    chk("R5 failover", int'(mux_sel), 1);
    chk("R10 onehot after failover", int'(sel_onehot), 2);
    run[0] = 1'b1; cyc(40);
    chk("R8 held before clear", int'(mux_sel), 1);
    pulse_clr(); cyc(12);
    chk("R8 return after clear", int'(mux_sel), 0);

    // clear while primary still dead keeps secondary
    freeze(0, 1'b0);
    chk("R5 failover again", int'(mux_sel), 1);
    pulse_clr(); cyc(10);
    chk("R8 held primary dead", int'(mux_sel), 1);
    cyc(LIM + 5);
    chk("R8 held after re-alarm", int'(mux_sel), 1);

    // both inputs bad
    freeze(1, 1'b0);
    chk("R9 both bad", int'(alarm), 3);
    chk("R9 hold", int'(mux_sel), 1);
    cyc(20);
    chk("R9 still held", int'(mux_sel), 1);
    run = 2'b11; cyc(10); pulse_clr(); cyc(12);
    chk("R8 return after both recover", int'(mux_sel), 0);

    // override
    override = 1'b1; sel_pin = 1'b1; cyc(2);
    chk("R7 follows pin", int'(mux_sel), 1);
    freeze(1, 1'b1);
    chk("R7 no auto move", int'(mux_sel), 1);
    sel_pin = 1'b0; cyc(2);
    chk("R7 follows pin back", int'(mux_sel), 0);
    chk("R7 alarm kept", int'(alarm[1]), 1);

    report();
  end
endmodule